// File: doc/BRIEF.md
# Flash protection and key lock unit

This unit guards an on-chip flash controller. It holds a 32-bit protection word whose bits are active-low: bits 30:0 each guard a group of four 512-byte pages of the 124-page user area, and bit 31 locks the user area against read-out through the debug port and the parallel programming port. Every program or erase request, from any path, and every debug or parallel read request is checked against this word, and the unit answers allow or deny. Requests aimed at pages 124 and above (the hidden firmware area) are always denied.

Software drives the unit through a small register file: an address register, a data register, a mode register (bits 7:4 kept), a command register, a directly writable protection view and a staged protection view. The direct view changes protection at once while no key lock is set. Once a 32-bit key has been stored, protection changes only by presenting that key with the key command, which then commits the staged view. Three wrong keys in a row start a mass erase of the flash, after which protection, key and lock return to their erased state. The flash array itself is replaced by a start/done handshake.

Top module: `flash_guard`

## Requirements
- R1: During reset the protection word loads from `shadow_prot_i` and the key from `shadow_key_i`; the key lock is set only when the shadow key is not all ones; the failure count and `status_o` read zero after reset.
- R2: A program/erase request on page p (`acc_kind_i`=1, any path) or a program (0x02) / erase (0x05) command on page p = address register bits 15:9 is allowed only when p < 124 and protection bit p/4 is 1.
- R3: A read request (`acc_kind_i`=0) on a page below 124 is always allowed from the CPU path (`acc_path_i`=0) and is allowed from the debug (1) or parallel (2) path only when protection bit 31 is 1; pages 124 and above are denied on every path.
- R4: A denied program or erase command issues no `fl_start_o` and, one edge after the command write, shows `status_o` = 3'b101 (bit 0 done, bit 2 error).
- R5: An accepted read (0x01), verify (0x04) or allowed program/erase command raises `fl_start_o` for one cycle after the command edge with `fl_op_o` equal to the code; `status_o` bit 1 (busy) stays set until `fl_done_i`, after which `status_o` = 3'b001.
- R6: A command written while busy is ignored: no further `fl_start_o`, and busy holds until `fl_done_i`.
- R7: A write to the direct view (select 4) replaces the protection word after one edge when no key lock is set, and is ignored when the lock is set. Register selects: 0 address, 1 data, 2 mode, 3 command, 4 direct view, 5 staged view.
- R8: The key command 0x0C with mode bits 7:4 = 4'hF while unlocked stores key {address[15:0], data[15:0]}, commits the staged view and sets the lock; with mode bits 7:4 not all ones it changes nothing and ends with status 3'b101.
- R9: With the lock set, a key command presenting the stored key commits the staged view and clears the failure count.
- R10: With the lock set, a wrong key leaves protection unchanged, increments the 2-bit failure count and ends with status 3'b101; the third consecutive wrong key starts a mass erase (`fl_op_o` = 0x06, `mass_erase_req_o` high, status 3'b110) and the count holds at 3 until it finishes.
- R11: When the mass erase completes, the protection word becomes all ones, the key all ones, the lock and the failure count clear and `mass_erase_req_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shadow_prot_i | input | 32 | Nonvolatile copy of the protection word |
| shadow_key_i | input | 32 | Nonvolatile copy of the key |
| bus_we_i | input | 1 | Register write strobe |
| bus_sel_i | input | 3 | Register select |
| bus_wdata_i | input | 32 | Register write data |
| status_o | output | 3 | {error, busy, done} |
| prot_word_o | output | 32 | Current protection word |
| key_locked_o | output | 1 | Key lock set |
| fail_cnt_o | output | 2 | Consecutive wrong-key count |
| mass_erase_req_o | output | 1 | Mass erase in progress |
| acc_valid_i | input | 1 | External access request valid |
| acc_path_i | input | 2 | 0 CPU, 1 debug, 2 parallel |
| acc_kind_i | input | 1 | 0 read, 1 program/erase |
| acc_page_i | input | 7 | Target page |
| acc_allow_o | output | 1 | Request permitted |
| fl_start_o | output | 1 | Start pulse to flash model |
| fl_op_o | output | 8 | Operation code to flash model |
| fl_addr_o | output | 16 | Address to flash model |
| fl_wdata_o | output | 16 | Data to flash model |
| fl_done_i | input | 1 | Completion pulse from flash model |

## Verification
The hardest state to reach is the mass erase, which needs an armed mode, a stored key, the lock set and then three consecutive wrong keys without a correct one in between. The stimulus stores a key, shows a wrong key raising the count, resets it with the correct key, then presents three wrong keys and lets the stand-in flash model finish the erase before probing that the direct view works again.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam logic [2:0] SEL_ADDR  = 3'd0;
    localparam logic [2:0] SEL_DATA  = 3'd1;
    localparam logic [2:0] SEL_MODE  = 3'd2;
    localparam logic [2:0] SEL_CMD   = 3'd3;
    localparam logic [2:0] SEL_PROT  = 3'd4;
    localparam logic [2:0] SEL_STAGE = 3'd5;

    localparam logic [7:0] OP_READ   = 8'h01;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_VERIFY = 8'h04;
    localparam logic [7:0] OP_ERASE  = 8'h05;
    localparam logic [7:0] OP_MASS   = 8'h06;
    localparam logic [7:0] OP_KEY    = 8'h0C;

    localparam logic [1:0] PATH_CPU  = 2'd0;

    typedef struct packed {
        logic       busy;
        logic       done;
        logic       err;
        logic       start;
        logic [7:0] op;
    } seq_t;
endpackage

// File: rtl/fg_prot_check.sv
module fg_prot_check #(
    parameter int PAGE_W     = 7,
    parameter int NUM_PAGES  = 124,
    parameter int GROUP_LOG2 = 2,
    parameter int PROT_W     = 32
) (
    input  logic [PROT_W-1:0] prot_i,
    input  logic [1:0]        path_i,
    input  logic              is_write_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              allow_o
);
    import fg_pkg::*;
    localparam logic [PAGE_W-1:0] PAGE_LIMIT = PAGE_W'(NUM_PAGES);
    localparam int GRP_W = PAGE_W - GROUP_LOG2;

    logic             in_range;
    logic [GRP_W-1:0] group;
    logic             grp_open;
    logic             read_open;

    always_comb begin
        in_range  = page_i < PAGE_LIMIT;
        group     = page_i[PAGE_W-1:GROUP_LOG2];
        grp_open  = prot_i[group];
        read_open = (path_i == PATH_CPU) || prot_i[PROT_W-1];
        allow_o   = in_range && (is_write_i ? grp_open : read_open);
    end
endmodule

// File: rtl/fg_key_unit.sv
module fg_key_unit #(
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] shadow_key_i,
    input  logic             key_fire_i,
    input  logic             armed_i,
    input  logic [KEY_W-1:0] presented_i,
    input  logic             erase_done_i,
    output logic [KEY_W-1:0] key_o,
    output logic             locked_o,
    output logic [1:0]       fail_cnt_o,
    output logic             commit_o,
    output logic             start_erase_o,
    output logic             reject_o
);
    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             locked;
        logic [1:0]       fail;
    } key_t;

    key_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        commit_o      = 1'b0;
        start_erase_o = 1'b0;
        reject_o      = 1'b0;
        if (erase_done_i) begin
            st_d.key    = '1;
            st_d.locked = 1'b0;
            st_d.fail   = 2'd0;
        end else if (key_fire_i) begin
            if (!armed_i) begin
                reject_o = 1'b1;
            end else if (!st_q.locked) begin
                st_d.key    = presented_i;
                st_d.locked = 1'b1;
                st_d.fail   = 2'd0;
                commit_o    = 1'b1;
            end else if (presented_i == st_q.key) begin
                st_d.fail = 2'd0;
                commit_o  = 1'b1;
            end else begin
                reject_o = 1'b1;
                if (st_q.fail == 2'd2) begin
                    st_d.fail     = 2'd3;
                    start_erase_o = 1'b1;
                end else if (st_q.fail != 2'd3) begin
                    st_d.fail = st_q.fail + 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.key    <= shadow_key_i;
            st_q.locked <= (shadow_key_i != '1);
            st_q.fail   <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_o      = st_q.key;
    assign locked_o   = st_q.locked;
    assign fail_cnt_o = st_q.fail;
endmodule

// File: rtl/fg_cmd_seq.sv
module fg_cmd_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr_i,
    input  logic [7:0] cmd_code_i,
    input  logic       prog_allow_i,
    input  logic       start_erase_i,
    input  logic       key_reject_i,
    input  logic       fl_done_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic       fl_start_o,
    output logic [7:0] fl_op_o,
    output logic       key_fire_o,
    output logic       erase_done_o,
    output logic       erase_active_o
);
    import fg_pkg::*;

    seq_t sq_d, sq_q;
    logic accept;

    always_comb begin
        accept       = cmd_wr_i && !sq_q.busy;
        key_fire_o   = accept && (cmd_code_i == OP_KEY);
        erase_done_o = sq_q.busy && fl_done_i && (sq_q.op == OP_MASS);

        sq_d       = sq_q;
        sq_d.start = 1'b0;
        if (sq_q.busy) begin
            if (fl_done_i) begin
                sq_d.busy = 1'b0;
                sq_d.done = 1'b1;
            end
        end else if (accept) begin
            sq_d.done = 1'b0;
            sq_d.err  = 1'b0;
            case (cmd_code_i)
                OP_READ, OP_VERIFY: begin
                    sq_d.busy  = 1'b1;
                    sq_d.start = 1'b1;
                    sq_d.op    = cmd_code_i;
                end
                OP_PROG, OP_ERASE: begin
                    if (prog_allow_i) begin
                        sq_d.busy  = 1'b1;
                        sq_d.start = 1'b1;
                        sq_d.op    = cmd_code_i;
                    end else begin
                        sq_d.done = 1'b1;
                        sq_d.err  = 1'b1;
                    end
                end
                OP_KEY: begin
                    if (start_erase_i) begin
                        sq_d.busy  = 1'b1;
                        sq_d.start = 1'b1;
                        sq_d.op    = OP_MASS;
                        sq_d.err   = 1'b1;
                    end else begin
                        sq_d.done = 1'b1;
                        sq_d.err  = key_reject_i;
                    end
                end
                default: begin
                    sq_d.done = 1'b1;
                    sq_d.err  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_o         = sq_q.busy;
    assign done_o         = sq_q.done;
    assign err_o          = sq_q.err;
    assign fl_start_o     = sq_q.start;
    assign fl_op_o        = sq_q.op;
    assign erase_active_o = sq_q.busy && (sq_q.op == OP_MASS);
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int PAGE_LOG2  = 9,
    parameter int NUM_PAGES  = 124,
    parameter int GROUP_LOG2 = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [31:0]                 shadow_prot_i,
    input  logic [ADDR_W+DATA_W-1:0]    shadow_key_i,
    input  logic                        bus_we_i,
    input  logic [2:0]                  bus_sel_i,
    input  logic [31:0]                 bus_wdata_i,
    output logic [2:0]                  status_o,
    output logic [31:0]                 prot_word_o,
    output logic                        key_locked_o,
    output logic [1:0]                  fail_cnt_o,
    output logic                        mass_erase_req_o,
    input  logic                        acc_valid_i,
    input  logic [1:0]                  acc_path_i,
    input  logic                        acc_kind_i,
    input  logic [ADDR_W-PAGE_LOG2-1:0] acc_page_i,
    output logic                        acc_allow_o,
    output logic                        fl_start_o,
    output logic [7:0]                  fl_op_o,
    output logic [ADDR_W-1:0]           fl_addr_o,
    output logic [DATA_W-1:0]           fl_wdata_o,
    input  logic                        fl_done_i
);
    import fg_pkg::*;

    localparam int PAGE_W = ADDR_W - PAGE_LOG2;
    localparam int PROT_W = (NUM_PAGES >> GROUP_LOG2) + 1;
    localparam int KEY_W  = ADDR_W + DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [3:0]        mode;
        logic [PROT_W-1:0] prot;
        logic [PROT_W-1:0] stage;
    } regs_t;

    regs_t rg_d, rg_q;

    logic             cmd_wr;
    logic             cmd_allow;
    logic             acc_raw_allow;
    logic             key_fire;
    logic             commit;
    logic             start_erase;
    logic             key_reject;
    logic             erase_done;
    logic             busy, done, err;
    logic [KEY_W-1:0] key_val;

    assign cmd_wr = bus_we_i && (bus_sel_i == SEL_CMD);

    fg_prot_check #(
        .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES),
        .GROUP_LOG2(GROUP_LOG2), .PROT_W(PROT_W)
    ) u_cmd_chk (
        .prot_i(rg_q.prot), .path_i(PATH_CPU), .is_write_i(1'b1),
        .page_i(rg_q.addr[ADDR_W-1:PAGE_LOG2]), .allow_o(cmd_allow)
    );

    fg_prot_check #(
        .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES),
        .GROUP_LOG2(GROUP_LOG2), .PROT_W(PROT_W)
    ) u_acc_chk (
        .prot_i(rg_q.prot), .path_i(acc_path_i), .is_write_i(acc_kind_i),
        .page_i(acc_page_i), .allow_o(acc_raw_allow)
    );

    fg_key_unit #(.KEY_W(KEY_W)) u_key (
        .clk(clk), .rst_n(rst_n), .shadow_key_i(shadow_key_i),
        .key_fire_i(key_fire), .armed_i(rg_q.mode == 4'hF),
        .presented_i({rg_q.addr, rg_q.data}), .erase_done_i(erase_done),
        .key_o(key_val), .locked_o(key_locked_o), .fail_cnt_o(fail_cnt_o),
        .commit_o(commit), .start_erase_o(start_erase), .reject_o(key_reject)
    );

    fg_cmd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr),
        .cmd_code_i(bus_wdata_i[7:0]), .prog_allow_i(cmd_allow),
        .start_erase_i(start_erase), .key_reject_i(key_reject),
        .fl_done_i(fl_done_i), .busy_o(busy), .done_o(done), .err_o(err),
        .fl_start_o(fl_start_o), .fl_op_o(fl_op_o), .key_fire_o(key_fire),
        .erase_done_o(erase_done), .erase_active_o(mass_erase_req_o)
    );

    always_comb begin
        rg_d = rg_q;
        if (bus_we_i) begin
            case (bus_sel_i)
                SEL_ADDR:  rg_d.addr  = bus_wdata_i[ADDR_W-1:0];
                SEL_DATA:  rg_d.data  = bus_wdata_i[DATA_W-1:0];
                SEL_MODE:  rg_d.mode  = bus_wdata_i[7:4];
                SEL_PROT:  if (!key_locked_o) rg_d.prot = bus_wdata_i[PROT_W-1:0];
                SEL_STAGE: rg_d.stage = bus_wdata_i[PROT_W-1:0];
                default: ;
            endcase
        end
        if (commit)     rg_d.prot = rg_q.stage;
        if (erase_done) rg_d.prot = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q.addr  <= '0;
            rg_q.data  <= '0;
            rg_q.mode  <= '0;
            rg_q.prot  <= shadow_prot_i[PROT_W-1:0];
            rg_q.stage <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign status_o    = {err, busy, done};
    assign prot_word_o = 32'(rg_q.prot);
    assign acc_allow_o = acc_valid_i && acc_raw_allow;
    assign fl_addr_o   = rg_q.addr;
    assign fl_wdata_o  = rg_q.data;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we_i,
    input logic [2:0]  bus_sel_i,
    input logic [2:0]  status_o,
    input logic [31:0] prot_word_o,
    input logic        key_locked_o,
    input logic [1:0]  fail_cnt_o,
    input logic        mass_erase_req_o,
    input logic        acc_valid_i,
    input logic [1:0]  acc_path_i,
    input logic        acc_kind_i,
    input logic [6:0]  acc_page_i,
    input logic        acc_allow_o,
    input logic        fl_start_o,
    input logic        fl_done_i,
    input logic [31:0] key_val
);
    AST_START_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fl_start_o |-> status_o[1]); // R5

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[1] && !fl_done_i) |=> status_o[1]); // R6

    AST_READOUT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_path_i != 2'd0 && !acc_kind_i && !prot_word_o[31]) |-> !acc_allow_o); // R3

    AST_GROUP_WRITE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_kind_i && !prot_word_o[acc_page_i[6:2]]) |-> !acc_allow_o); // R2

    AST_LOCKED_DIRECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (key_locked_o && bus_we_i && bus_sel_i == 3'd4 && !mass_erase_req_o) |=> $stable(prot_word_o)); // R7

    AST_FAIL_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt_o == 2'd3) |-> mass_erase_req_o); // R10

    AST_ERASE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (mass_erase_req_o && fl_done_i) |=> (key_val == '1 && !key_locked_o && fail_cnt_o == 2'd0 && prot_word_o == '1)); // R11
endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we_i), .bus_sel_i(bus_sel_i),
    .status_o(status_o), .prot_word_o(prot_word_o), .key_locked_o(key_locked_o),
    .fail_cnt_o(fail_cnt_o), .mass_erase_req_o(mass_erase_req_o),
    .acc_valid_i(acc_valid_i), .acc_path_i(acc_path_i), .acc_kind_i(acc_kind_i),
    .acc_page_i(acc_page_i), .acc_allow_o(acc_allow_o), .fl_start_o(fl_start_o),
    .fl_done_i(fl_done_i), .key_val(key_val)
);

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] shadow_prot = 32'hFFFF_FFFF;
    logic [31:0] shadow_key  = 32'hFFFF_FFFF;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  status;
    logic [31:0] prot_word;
    logic        key_locked;
    logic [1:0]  fail_cnt;
    logic        mass_req;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_path = 2'd0;
    logic        acc_kind = 1'b0;
    logic [6:0]  acc_page = 7'd0;
    logic        acc_allow;
    logic        fl_start;
    logic [7:0]  fl_op;
    logic [15:0] fl_addr;
    logic [15:0] fl_wdata;
    logic        fl_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int starts = 0;
    int fl_cnt = 0;
    int s0;

    always #2.5 clk = ~clk;

    flash_guard u_dut (
        .clk(clk), .rst_n(rst_n), .shadow_prot_i(shadow_prot), .shadow_key_i(shadow_key),
        .bus_we_i(bus_we), .bus_sel_i(bus_sel), .bus_wdata_i(bus_wdata),
        .status_o(status), .prot_word_o(prot_word), .key_locked_o(key_locked),
        .fail_cnt_o(fail_cnt), .mass_erase_req_o(mass_req),
        .acc_valid_i(acc_valid), .acc_path_i(acc_path), .acc_kind_i(acc_kind),
        .acc_page_i(acc_page), .acc_allow_o(acc_allow),
        .fl_start_o(fl_start), .fl_op_o(fl_op), .fl_addr_o(fl_addr),
        .fl_wdata_o(fl_wdata), .fl_done_i(fl_done)
    );

    // stand-in flash: done pulse three cycles after a start
    always @(negedge clk) begin
        fl_done = 1'b0;
        if (fl_cnt != 0) begin
            fl_cnt = fl_cnt - 1;
            if (fl_cnt == 0) fl_done = 1'b1;
        end
        if (fl_start) begin
            starts = starts + 1;
            fl_cnt = 3;
        end
    end

    // {path[1:0], kind, page[6:0], expected}, protection word 0x7FFFFFFD
    localparam int NVEC = 10;
    localparam logic [10:0] VECS [NVEC] = '{
        {2'd0, 1'b1, 7'd3,   1'b1},
        {2'd0, 1'b1, 7'd4,   1'b0},
        {2'd1, 1'b1, 7'd7,   1'b0},
        {2'd2, 1'b1, 7'd8,   1'b1},
        {2'd0, 1'b1, 7'd123, 1'b1},
        {2'd0, 1'b1, 7'd124, 1'b0},
        {2'd0, 1'b0, 7'd5,   1'b1},
        {2'd1, 1'b0, 7'd5,   1'b0},
        {2'd2, 1'b0, 7'd0,   1'b0},
        {2'd0, 1'b0, 7'd124, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] v);
        bus_we = 1'b1; bus_sel = s; bus_wdata = v;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50; i++) begin
            if (!status[1]) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 prot after reset", prot_word, 32'hFFFF_FFFF);
        chk("R1 lock after virgin reset", {31'd0, key_locked}, 32'd0);
        chk("R1 status after reset", {29'd0, status}, 32'd0);
        chk("R1 fail count after reset", {30'd0, fail_cnt}, 32'd0);

        wr(3'd4, 32'h7FFF_FFFD);
        chk("R7 direct view applied", prot_word, 32'h7FFF_FFFD);

        acc_valid = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            acc_path = VECS[i][10:9];
            acc_kind = VECS[i][8];
            acc_page = VECS[i][7:1];
            #1;
            chk(VECS[i][8] ? "R2 write gate vector" : "R3 read gate vector",
                {31'd0, acc_allow}, {31'd0, VECS[i][0]});
            @(negedge clk);
        end
        acc_valid = 1'b0;
        #1;
        chk("R3 no grant without valid", {31'd0, acc_allow}, 32'd0);

        // R4: program page 5 (group 1 cleared) is denied
        wr(3'd0, 32'h0000_0A00);
        s0 = starts;
        wr(3'd3, 32'h02);
        chk("R4 denied status", {29'd0, status}, 32'b101);
        @(negedge clk);
        chk("R4 no flash start", starts, s0);

        // R5/R6: program page 8 allowed, second command while busy ignored
        wr(3'd0, 32'h0000_1000);
        s0 = starts;
        wr(3'd3, 32'h02);
        chk("R5 busy after start", {29'd0, status}, 32'b010);
        chk("R5 op code", {24'd0, fl_op}, 32'h02);
        wr(3'd3, 32'h01);
        wait_idle();
        chk("R5 done after flash", {29'd0, status}, 32'b001);
        chk("R6 single start while busy", starts, s0 + 1);

        // R8: key command without armed mode
        wr(3'd2, 32'h00);
        wr(3'd3, 32'h0C);
        chk("R8 unarmed key status", {29'd0, status}, 32'b101);
        chk("R8 unarmed leaves unlocked", {31'd0, key_locked}, 32'd0);

        // R8: store key 0xAA55AA55
        wr(3'd2, 32'hF0);
        wr(3'd5, 32'hFFFF_FFF0);
        wr(3'd0, 32'h0000_AA55);
        wr(3'd1, 32'h0000_AA55);
        wr(3'd3, 32'h0C);
        chk("R8 lock set", {31'd0, key_locked}, 32'd1);
        chk("R8 staged committed", prot_word, 32'hFFFF_FFF0);
        chk("R8 key status", {29'd0, status}, 32'b001);

        wr(3'd4, 32'hFFFF_FFFF);
        chk("R7 direct view ignored when locked", prot_word, 32'hFFFF_FFF0);

        // R10: one wrong key
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0000_1234);
        wr(3'd3, 32'h0C);
        chk("R10 fail count one", {30'd0, fail_cnt}, 32'd1);
        chk("R10 prot unchanged", prot_word, 32'hFFFF_FFF0);
        chk("R10 wrong key status", {29'd0, status}, 32'b101);

        // R9: correct key
        wr(3'd5, 32'hFFFF_FFFE);
        wr(3'd0, 32'h0000_AA55);
        wr(3'd3, 32'h0C);
        chk("R9 commit with key", prot_word, 32'hFFFF_FFFE);
        chk("R9 fail count cleared", {30'd0, fail_cnt}, 32'd0);

        // R10: three wrong keys start a mass erase
        wr(3'd0, 32'h0000_0001);
        wr(3'd3, 32'h0C);
        wr(3'd3, 32'h0C);
        chk("R10 fail count two", {30'd0, fail_cnt}, 32'd2);
        s0 = starts;
        wr(3'd3, 32'h0C);
        chk("R10 mass erase requested", {31'd0, mass_req}, 32'd1);
        chk("R10 erase status", {29'd0, status}, 32'b110);
        chk("R10 erase op", {24'd0, fl_op}, 32'h06);
        chk("R10 count saturated", {30'd0, fail_cnt}, 32'd3);
        wait_idle();
        chk("R11 prot wiped", prot_word, 32'hFFFF_FFFF);
        chk("R11 lock cleared", {31'd0, key_locked}, 32'd0);
        chk("R11 fail cleared", {30'd0, fail_cnt}, 32'd0);
        chk("R11 request dropped", {31'd0, mass_req}, 32'd0);
        chk("R11 one erase start", starts, s0 + 1);
        wr(3'd4, 32'h1234_5678);
        chk("R11 direct view usable after erase", prot_word, 32'h1234_5678);

        // R1: reset from a programmed shadow
        rst_n = 1'b0;
        shadow_key  = 32'h1111_2222;
        shadow_prot = 32'h7FFF_FFFF;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 prot from shadow", prot_word, 32'h7FFF_FFFF);
        chk("R1 lock from shadow key", {31'd0, key_locked}, 32'd1);
        chk("R1 status cleared", {29'd0, status}, 32'd0);

        finish_run();
    end
endmodule